// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block tells a DRAM command sequencer when an auto-refresh is due. The device must see every row refreshed within its retention time. The block does not send all refreshes in one burst. It spreads them evenly: an interval timer counts clock cycles, and each time the interval runs out, one more refresh is owed. The block keeps no row address. The memory steps its own internal row pointer on each auto-refresh, so the only state needed here is the timer and the number of refreshes still owed.

The owed count drives a request line. The sequencer answers with a one-cycle acknowledge each time it issues a refresh command. The sequencer may put refreshes off while it serves traffic, up to a fixed number of intervals. It can then issue the backlog back to back. An urgent output rises once the backlog reaches a programmable level, so the sequencer can give refresh priority over reads and writes. If the backlog would grow past its limit, a sticky error flag is raised, because data retention can no longer be guaranteed. A mode input selects between a standard interval of about 7.8 µs and a longer interval of about 15 µs for double-data-rate parts. Both intervals are parameters in clock cycles. An enable input keeps the timer idle until the memory has been initialised.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `refresh_req`, `refresh_urgent` and `retention_err` are low and no refresh is owed.
- R2: While `timer_en` is low, the interval timer stays cleared and no refresh becomes owed. With `rate_ddr` = 0, the first request appears exactly `STD_CYCLES` clock edges after the first edge at which `timer_en` is sampled high.
- R3: With `rate_ddr` = 1, the interval is `DDR_CYCLES` clock edges instead.
- R4: Each interval expiry adds one owed refresh. `refresh_req` is high exactly while the owed count is nonzero.
- R5: A sampled `refresh_ack` removes one owed refresh. An acknowledge while nothing is owed is ignored: the count stays zero and the next expiry still yields exactly one owed refresh.
- R6: An expiry and an acknowledge in the same cycle leave the owed count unchanged.
- R7: `refresh_urgent` is high exactly when the owed count is nonzero and greater than or equal to `urgent_level`.
- R8: The owed count saturates at `MAX_OWED` (default 8). An expiry while `MAX_OWED` refreshes are owed and no acknowledge is given sets `retention_err`. The count stays at `MAX_OWED`.
- R9: `retention_err` stays set until `err_clear` is sampled high. If a new overflow occurs in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_en | input | 1 | Runs the interval timer; low holds it cleared |
| rate_ddr | input | 1 | 0: standard interval, 1: double-data-rate interval |
| refresh_ack | input | 1 | One refresh command issued this cycle |
| urgent_level | input | $clog2(MAX_OWED+1) | Owed count at which urgent asserts |
| err_clear | input | 1 | Clears the sticky retention error |
| refresh_req | output | 1 | At least one refresh is owed |
| refresh_urgent | output | 1 | Owed count has reached `urgent_level` |
| retention_err | output | 1 | Sticky: backlog exceeded `MAX_OWED` |

## Verification
The bench runs a short-interval configuration (10 and 17 cycles). It compares every cycle against an arithmetic model of the timer and the owed count. The first-request latency is measured separately in each rate mode, which separates the two intervals and catches off-by-one reload errors. Acknowledges are placed on the expiry cycle, on idle cycles and while nothing is owed, which separates the R6 coincidence rule from the plain decrement and from the ignored acknowledge. The backlog is filled to saturation while `urgent_level` is swept over every value at each depth. It is then drained and counted, and clears are placed both alone and on an overflow cycle to check the sticky flag and which of clear and overflow wins.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

    typedef enum logic {
        RATE_STD = 1'b0,
        RATE_DDR = 1'b1
    } rate_mode_e;

    function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer
    import refresh_sched_pkg::*;
#(
    parameter int unsigned STD_CYCLES = 780,
    parameter int unsigned DDR_CYCLES = 1500,
    parameter int unsigned CNT_W      = $clog2(larger_of(STD_CYCLES, DDR_CYCLES))
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  rate_mode_e mode,
    output logic       expire
);

    localparam logic [CNT_W-1:0] STD_LAST = CNT_W'(STD_CYCLES - 1);
    localparam logic [CNT_W-1:0] DDR_LAST = CNT_W'(DDR_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W-1:0] last_d;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        last_d = (mode == RATE_DDR) ? DDR_LAST : STD_LAST;
        if (!run) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= last_d) begin
            expire   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // idle timer holds no progress
    assert_idle_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));

    // expiries are never adjacent (intervals are at least two cycles)
    assert_no_adjacent_expiry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // counter never walks past the longer limit
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt <= ((STD_LAST > DDR_LAST) ? STD_LAST : DDR_LAST)));

endmodule

// File: rtl/refresh_owed_counter.sv
module refresh_owed_counter #(
    parameter int unsigned MAX_OWED = 8,
    parameter int unsigned OW_W     = $clog2(MAX_OWED + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            expire,
    input  logic            ack,
    input  logic [OW_W-1:0] urgent_level,
    input  logic            err_clear,
    output logic            req,
    output logic            urgent,
    output logic            err
);

    localparam logic [OW_W-1:0] FULL = OW_W'(MAX_OWED);

    typedef struct packed {
        logic [OW_W-1:0] owed;
        logic            err;
    } owed_state_t;

    owed_state_t st_d, st_q;
    logic take_d;
    logic ovf_d;

    always_comb begin
        st_d   = st_q;
        take_d = ack && (st_q.owed != '0);
        ovf_d  = 1'b0;
        if (expire && !take_d) begin
            if (st_q.owed == FULL) begin
                ovf_d = 1'b1;
            end else begin
                st_d.owed = st_q.owed + 1'b1;
            end
        end else if (!expire && take_d) begin
            st_d.owed = st_q.owed - 1'b1;
        end
        st_d.err = ovf_d || (st_q.err && !err_clear);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = (st_q.owed != '0);
    assign urgent = (st_q.owed != '0) && (st_q.owed >= urgent_level);
    assign err    = st_q.err;

    assert_owed_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.owed <= FULL);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !err_clear) |=> st_q.err);

    assert_err_rise_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.err) |-> ($past(st_q.owed) == FULL));

    assert_ack_empty_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.owed == '0 && !expire) |=> (st_q.owed == '0));

    assert_both_unchanged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ack && st_q.owed != '0) |=> $stable(st_q.owed));

    assert_expire_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ack && st_q.owed != FULL) |=> (st_q.owed == $past(st_q.owed) + 1'b1));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refresh_sched_pkg::*;
#(
    parameter int unsigned STD_CYCLES = 780,
    parameter int unsigned DDR_CYCLES = 1500,
    parameter int unsigned MAX_OWED   = 8,
    localparam int unsigned OW_W      = $clog2(MAX_OWED + 1),
    localparam int unsigned CNT_W     = $clog2(larger_of(STD_CYCLES, DDR_CYCLES))
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            timer_en,
    input  logic            rate_ddr,
    input  logic            refresh_ack,
    input  logic [OW_W-1:0] urgent_level,
    input  logic            err_clear,
    output logic            refresh_req,
    output logic            refresh_urgent,
    output logic            retention_err
);

    logic       expire;
    rate_mode_e mode;

    assign mode = rate_mode_e'(rate_ddr);

    refresh_interval_timer #(
        .STD_CYCLES (STD_CYCLES),
        .DDR_CYCLES (DDR_CYCLES),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_en),
        .mode   (mode),
        .expire (expire)
    );

    refresh_owed_counter #(
        .MAX_OWED (MAX_OWED),
        .OW_W     (OW_W)
    ) u_owed (
        .clk          (clk),
        .rst_n        (rst_n),
        .expire       (expire),
        .ack          (refresh_ack),
        .urgent_level (urgent_level),
        .err_clear    (err_clear),
        .req          (refresh_req),
        .urgent       (refresh_urgent),
        .err          (retention_err)
    );

    assert_urgent_implies_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_urgent |-> refresh_req);

    assert_err_needs_backlog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retention_err) |-> $past(refresh_req));

endmodule

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int STD_P      = 10;
    localparam int DDR_P      = 17;
    localparam int MAXO       = 8;
    localparam int OW_W       = $clog2(MAXO + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic timer_en, rate_ddr, refresh_ack, err_clear;
    logic [OW_W-1:0] urgent_level;
    logic refresh_req, refresh_urgent, retention_err;

    int tests_run = 0;
    int tests_failed = 0;
    int m_cnt, m_owed, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sched #(
        .STD_CYCLES (STD_P),
        .DDR_CYCLES (DDR_P),
        .MAX_OWED   (MAXO)
    ) u_refresh_sched (
        .clk            (clk),
        .rst_n          (rst_n),
        .timer_en       (timer_en),
        .rate_ddr       (rate_ddr),
        .refresh_ack    (refresh_ack),
        .urgent_level   (urgent_level),
        .err_clear      (err_clear),
        .refresh_req    (refresh_req),
        .refresh_urgent (refresh_urgent),
        .retention_err  (retention_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_urgent();
        return (m_owed != 0 && m_owed >= int'(urgent_level)) ? 1 : 0;
    endfunction

    task automatic compare(input string tag);
        int packed_act, packed_exp;
        packed_act = {29'd0, refresh_req, refresh_urgent, retention_err};
        packed_exp = ((m_owed != 0) ? 4 : 0) + exp_urgent() * 2 + m_err;
        chk(packed_act == packed_exp, tag, packed_act, packed_exp);
    endtask

    // one clock: drive inputs, advance model, sample at next falling edge
    task automatic cyc(input logic en, input logic md, input logic ak, input logic cl,
                       input string tag);
        int last, tk, take, ovf;
        timer_en = en; rate_ddr = md; refresh_ack = ak; err_clear = cl;
        last = (md ? DDR_P : STD_P) - 1;
        tk = (en && m_cnt >= last) ? 1 : 0;
        take = (ak && m_owed != 0) ? 1 : 0;
        ovf = 0;
        if (tk && !take) begin
            if (m_owed == MAXO) ovf = 1; else m_owed++;
        end else if (!tk && take) begin
            m_owed--;
        end
        m_err = (ovf || (m_err && !cl)) ? 1 : 0;
        m_cnt = !en ? 0 : (tk ? 0 : m_cnt + 1);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        tests_failed++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        int n, drained;
        rst_n = 1'b0; timer_en = 0; rate_ddr = 0; refresh_ack = 0; err_clear = 0;
        urgent_level = OW_W'(6);
        m_cnt = 0; m_owed = 0; m_err = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(refresh_req == 0, "R1 req after reset", refresh_req, 0);
        chk(refresh_urgent == 0, "R1 urgent after reset", refresh_urgent, 0);
        chk(retention_err == 0, "R1 err after reset", retention_err, 0);
        rst_n = 1'b1;

        // R2 idle timer, R5 acks while nothing owed
        for (int i = 0; i < 30; i++) cyc(0, 0, i[0], 0, "R2 idle/R5 ack empty");

        // R2 first request latency, standard rate
        n = 0;
        do begin cyc(1, 0, 0, 0, "R2 latency"); n++; end while (!refresh_req && n < 60);
        chk(n == STD_P, "R2 std latency", n, STD_P);

        // R6 ack on the expiry cycle keeps count at one
        while (m_cnt != STD_P - 1) cyc(1, 0, 0, 0, "R4 wait");
        cyc(1, 0, 1, 0, "R6 coincident");
        chk(m_owed == 1 && refresh_req == 1, "R6 owed kept", refresh_req, 1);

        // R5 plain ack removes one
        if (m_cnt == STD_P - 1) cyc(1, 0, 0, 0, "R4 step");
        cyc(1, 0, 1, 0, "R5 ack");
        chk(refresh_req == 0, "R5 drained", refresh_req, 0);
        for (int i = 0; i < 12; i++) cyc(1, 0, 1, 0, "R5 ack while empty");
        // ignored acks: next expiry gives exactly one
        while (!refresh_req) cyc(1, 0, 0, 0, "R5 wait");
        urgent_level = OW_W'(2);
        cyc(1, 0, 0, 0, "R5 single");
        chk(refresh_urgent == 0 && refresh_req == 1, "R5 exactly one owed", refresh_urgent, 0);
        while (refresh_req) cyc(0, 0, 1, 0, "R5 drain");

        // R3 double-data-rate interval
        cyc(0, 1, 0, 0, "R3 setup");
        n = 0;
        do begin cyc(1, 1, 0, 0, "R3 latency"); n++; end while (!refresh_req && n < 60);
        chk(n == DDR_P, "R3 ddr latency", n, DDR_P);

        // R7 urgent sweep at every depth, R4 accumulation
        for (int k = 1; k <= MAXO; k++) begin
            while (m_owed < k) cyc(1, 1, 0, 0, "R4 accumulate");
            for (int lv = 0; lv <= MAXO; lv++) begin
                urgent_level = OW_W'(lv);
                #1;
                chk(refresh_urgent == ((k >= lv) ? 1'b1 : 1'b0), "R7 urgent level",
                    refresh_urgent, (k >= lv) ? 1 : 0);
            end
        end
        urgent_level = OW_W'(6);

        // R8 overflow
        while (!m_err) cyc(1, 1, 0, 0, "R8 fill");
        chk(retention_err == 1, "R8 err set", retention_err, 1);
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, "R9 sticky");
        chk(retention_err == 1, "R9 still set", retention_err, 1);

        // R8 saturation: drain and count
        drained = 0;
        while (refresh_req && drained < 40) begin cyc(0, 0, 1, 0, "R8 drain"); drained++; end
        chk(drained == MAXO, "R8 saturated count", drained, MAXO);

        cyc(0, 0, 0, 1, "R9 clear");
        chk(retention_err == 0, "R9 cleared", retention_err, 0);

        // R9 clear on an overflow cycle keeps the flag
        while (m_owed < MAXO) cyc(1, 0, 0, 0, "R4 refill");
        while (m_cnt != STD_P - 1) cyc(1, 0, 0, 0, "R8 wait");
        cyc(1, 0, 0, 1, "R9 clear vs overflow");
        chk(retention_err == 1, "R9 overflow wins", retention_err, 1);
        cyc(1, 0, 0, 1, "R9 clear again");
        chk(retention_err == 0, "R9 second clear", retention_err, 0);

        // R4/R5/R6 mixed ack patterns in both modes
        for (int i = 0; i < 600; i++)
            cyc(1, (i >= 300), ((i % 3) == 0 || (i % 7) == 0), 0, "R4 mixed");
        for (int i = 0; i < 400; i++)
            cyc(1, (i[3]), ((i % 23) == 0), (i % 50) == 0, "R8 mixed");

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule